// File: doc/BRIEF.md
# DMA Transfer Counter with Shadow Reload

This block holds the byte count for a DMA transfer. Host software programs the count one byte at a time through byte-wide count registers. Those writes land in a shadow copy, and the live counter is left alone. A command write whose DMA bit is set copies the whole shadow into the live counter in one cycle. A transfer engine outside this block then consumes the live count. Each beat takes one or two bytes. The engine can also ask for the zero-means-maximum length at transfer start, and it forces the count to zero when the operation completes. That completion raises the terminal-count flag.

The top count byte has an identification feature. Until the host first writes it, a read of that byte returns a fixed chip identifier. After the first write, it returns the live top byte. A hard reset re-arms the identifier.

Top module: `dma_tcount`

## Requirements
- R1: After a synchronous active-low reset, the live count and every shadow byte are zero, and the terminal-count flag, the DMA-mode flag and the protocol-error flag are all low.
- R2: A write to count address 0 (low byte), 1 (middle byte) or 2 (high byte) changes only that shadow byte. The live count does not change, and the terminal-count flag is cleared on the next edge.
- R3: A write to address 3 (command) with bit 7 set copies the full shadow value into the live count on the next edge. It also sets the DMA-mode flag and clears the protocol-error flag.
- R4: A command write with bit 7 clear leaves the live count unchanged and clears the DMA-mode flag.
- R5: A read of address 2 returns the CHIP_ID parameter until address 2 has been written at least once. After that, it returns bits 23:16 of the live count.
- R6: A transfer-start pulse while the live count is zero loads 0x10000. While the count is nonzero, the pulse has no effect.
- R7: An accepted narrow beat decrements the live count by 1. An accepted wide beat decrements it by 2.
- R8: `beat_ready` is high only when the live count is nonzero and no completion or reload happens in the same cycle. While the count is zero, beats leave it at zero.
- R9: A completion pulse forces the live count to zero and sets the terminal-count flag. It takes precedence over every other event in the same cycle.
- R10: A wide beat taken at a count of 1 leaves the count at zero and sets the protocol-error flag. The count does not wrap.
- R11: Reads of address 0 and 1 return bits 7:0 and 15:8 of the live count. Reads of address 3 return zero.
- R12: A hard reset clears the record that the high byte was written, so that address 2 reads CHIP_ID again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address: 0..2 count bytes, 3 command |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational read data for host_addr |
| xfer_start | input | 1 | Transfer start; loads the maximum length when the count is zero |
| xfer_done | input | 1 | Operation complete; zeroes the count and sets terminal count |
| beat_valid | input | 1 | Transfer engine presents a beat |
| beat_wide | input | 1 | Beat carries two bytes instead of one |
| beat_ready | output | 1 | A presented beat is taken this cycle |
| live_count | output | 24 | Live transfer count |
| tc_flag | output | 1 | Terminal-count status |
| dma_mode | output | 1 | Last command requested DMA |
| proto_err | output | 1 | Sticky flag: wide beat taken at count 1 |

## Verification
The bench builds the block with the default three-byte counter and a 16-bit zero-length exponent, and overrides the chip identifier to 0x5C. The override means an identifier read can never be confused with a zero or default byte. Random shadow writes keep the middle and high bytes mostly zero, so live counts of 0, 1 and 2 come up often. That brings the saturating wide beat, beats offered at zero and the 0x10000 load within reach. Completion, reload and count writes are sometimes issued in the same cycle as beats, which exercises the priority order.

// File: rtl/dma_tcount_pkg.sv
// Package: shared types for the DMA transfer counter.
// Assumes: one counter event is resolved per clock; the encoding is internal.
package dma_tcount_pkg;

    localparam int BYTE_W = 8;

    // Resolved counter event, highest priority first in the arbiter.
    typedef enum logic [2:0] {
        EV_IDLE   = 3'd0,
        EV_DONE   = 3'd1,
        EV_RELOAD = 3'd2,
        EV_START  = 3'd3,
        EV_NARROW = 3'd4,
        EV_WIDE   = 3'd5
    } tcnt_ev_e;

endpackage

// File: rtl/tcnt_shadow_bank.sv
// Module: tcnt_shadow_bank
// Holds the host-written shadow copy of the transfer count, one register per
// byte, plus the flag that records a write to the top byte since reset.
// Assumes: byte addresses 0..NBYTES-1; the command address is NBYTES.
module tcnt_shadow_bank
    import dma_tcount_pkg::*;
#(
    parameter int NBYTES = 3,
    parameter int ADDR_W = 2,
    localparam int CNT_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  shadow,
    output logic              count_wr,
    output logic              hi_written
);

    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NBYTES - 1);

    logic [NBYTES-1:0] byte_hit;

    // One shadow register per count byte.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign byte_hit[i] = wr_en && (wr_addr == ADDR_W'(i));

        // Purpose: capture host data into this shadow byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[i*BYTE_W +: BYTE_W] <= '0;
            end else if (byte_hit[i]) begin
                shadow[i*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    assign count_wr = |byte_hit;

    // Purpose: remember that the top byte has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_written <= 1'b0;
        end else if (wr_en && (wr_addr == HI_ADDR)) begin
            hi_written <= 1'b1;
        end
    end

    AST_HI_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == HI_ADDR) |=> hi_written); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !count_wr |=> $stable(shadow)); // R2

endmodule

// File: rtl/tcnt_event_arb.sv
// Module: tcnt_event_arb
// Resolves the requests that touch the live counter into one event per cycle.
// Priority: completion, reload, zero-length start, beat.
// Assumes: requests are single-cycle and already synchronous to clk.
module tcnt_event_arb
    import dma_tcount_pkg::*;
(
    input  logic     done_req,
    input  logic     reload_req,
    input  logic     start_req,
    input  logic     beat_valid,
    input  logic     beat_wide,
    input  logic     count_zero,
    output logic     beat_ready,
    output tcnt_ev_e ev
);

    // Purpose: a beat may be taken only when the count is live and nothing stronger acts.
    assign beat_ready = !count_zero && !done_req && !reload_req;

    // Purpose: pick the single event that updates the counter this cycle.
    always_comb begin
        if (done_req) begin
            ev = EV_DONE;
        end else if (reload_req) begin
            ev = EV_RELOAD;
        end else if (start_req && count_zero) begin
            ev = EV_START;
        end else if (beat_valid && beat_ready) begin
            ev = beat_wide ? EV_WIDE : EV_NARROW;
        end else begin
            ev = EV_IDLE;
        end
    end

endmodule

// File: rtl/tcnt_live_counter.sv
// Module: tcnt_live_counter
// The live transfer count with its terminal-count, DMA-mode and
// protocol-error flags. Acts on the event chosen by the arbiter.
// Assumes: ZERO_LEN_EXP < CNT_W so the zero-length value fits.
module tcnt_live_counter
    import dma_tcount_pkg::*;
#(
    parameter int NBYTES       = 3,
    parameter int ZERO_LEN_EXP = 16,
    localparam int CNT_W = NBYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tcnt_ev_e         ev,
    input  logic [CNT_W-1:0] shadow,
    input  logic             count_wr,
    input  logic             cmd_wr,
    input  logic             cmd_dma,
    output logic [CNT_W-1:0] count,
    output logic             tc,
    output logic             dma_mode,
    output logic             perr
);

    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);
    localparam logic [CNT_W-1:0] ZERO_LEN = ONE << ZERO_LEN_EXP;

    // Purpose: update the live count for the resolved event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (ev)
                EV_DONE:   count <= '0;
                EV_RELOAD: count <= shadow;
                EV_START:  count <= ZERO_LEN;
                EV_NARROW: count <= count - ONE;
                EV_WIDE:   count <= (count == ONE) ? '0 : count - TWO;
                default:   count <= count;
            endcase
        end
    end

    // Purpose: set terminal count on completion, clear it on a count write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b0;
        end else if (ev == EV_DONE) begin
            tc <= 1'b1;
        end else if (count_wr) begin
            tc <= 1'b0;
        end
    end

    // Purpose: track the DMA bit of the latest command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_mode <= 1'b0;
        end else if (cmd_wr) begin
            dma_mode <= cmd_dma;
        end
    end

    // Purpose: sticky flag for a wide beat that would underflow; reload clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr <= 1'b0;
        end else if (ev == EV_RELOAD) begin
            perr <= 1'b0;
        end else if (ev == EV_WIDE && count == ONE) begin
            perr <= 1'b1;
        end
    end

    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_DONE) |=> (count == '0 && tc)); // R9

    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RELOAD) |=> (count == $past(shadow) && !perr)); // R3

    AST_ZERO_LEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_START) |=> (count == ZERO_LEN)); // R6

    AST_NARROW_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NARROW) |=> (count == $past(count) - ONE)); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_WIDE && count == ONE) |=> (count == '0 && perr)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IDLE) |=> $stable(count)); // R8

    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (count_wr && ev != EV_DONE) |=> !tc); // R2

endmodule

// File: rtl/tcnt_read_mux.sv
// Module: tcnt_read_mux
// Combinational host read path: count bytes of the live counter, with the
// top byte replaced by the chip identifier until it has been written.
// Assumes: the command address (NBYTES) and any higher address read zero.
module tcnt_read_mux
    import dma_tcount_pkg::*;
#(
    parameter int                NBYTES  = 3,
    parameter int                ADDR_W  = 2,
    parameter logic [BYTE_W-1:0] CHIP_ID = 8'hA5,
    localparam int CNT_W = NBYTES * BYTE_W
) (
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              hi_written,
    output logic [BYTE_W-1:0] rdata
);

    // Purpose: select the addressed byte, substituting the identifier when due.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (addr == ADDR_W'(k)) begin
                if (k == NBYTES - 1 && !hi_written) begin
                    rdata = CHIP_ID;
                end else begin
                    rdata = count[k*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Purpose: immediate check that the command slot never returns data.
    always_comb begin
        if (rst_n && addr == ADDR_W'(NBYTES)) begin
            AST_CMD_READS_ZERO: assert (rdata == '0); // R11
        end
    end

endmodule

// File: rtl/dma_tcount.sv
// Module: dma_tcount (top)
// DMA transfer counter: host-written shadow bytes, reload on a DMA command,
// per-beat decrement by a transfer engine, completion and terminal count.
// Assumes: one host access per cycle; engine pulses are synchronous to clk.
module dma_tcount
    import dma_tcount_pkg::*;
#(
    parameter int          NBYTES       = 3,
    parameter int          ZERO_LEN_EXP = 16,
    parameter int          CMD_DMA_BIT  = 7,
    parameter logic [7:0]  CHIP_ID      = 8'hA5,
    localparam int ADDR_W = $clog2(NBYTES + 1),
    localparam int CNT_W  = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic              beat_valid,
    input  logic              beat_wide,
    output logic              beat_ready,
    output logic [CNT_W-1:0]  live_count,
    output logic              tc_flag,
    output logic              dma_mode,
    output logic              proto_err
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NBYTES);

    logic [CNT_W-1:0] shadow;
    logic             count_wr;
    logic             hi_written;
    logic             cmd_wr;
    logic             reload_req;
    tcnt_ev_e         ev;

    assign cmd_wr     = host_wr && (host_addr == CMD_ADDR);
    assign reload_req = cmd_wr && host_wdata[CMD_DMA_BIT];

    tcnt_shadow_bank #(
        .NBYTES (NBYTES),
        .ADDR_W (ADDR_W)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr),
        .wr_addr    (host_addr),
        .wr_data    (host_wdata),
        .shadow     (shadow),
        .count_wr   (count_wr),
        .hi_written (hi_written)
    );

    tcnt_event_arb u_arb (
        .done_req   (xfer_done),
        .reload_req (reload_req),
        .start_req  (xfer_start),
        .beat_valid (beat_valid),
        .beat_wide  (beat_wide),
        .count_zero (live_count == '0),
        .beat_ready (beat_ready),
        .ev         (ev)
    );

    tcnt_live_counter #(
        .NBYTES       (NBYTES),
        .ZERO_LEN_EXP (ZERO_LEN_EXP)
    ) u_live (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .shadow   (shadow),
        .count_wr (count_wr),
        .cmd_wr   (cmd_wr),
        .cmd_dma  (host_wdata[CMD_DMA_BIT]),
        .count    (live_count),
        .tc       (tc_flag),
        .dma_mode (dma_mode),
        .perr     (proto_err)
    );

    tcnt_read_mux #(
        .NBYTES  (NBYTES),
        .ADDR_W  (ADDR_W),
        .CHIP_ID (CHIP_ID)
    ) u_rd (
        .rst_n      (rst_n),
        .addr       (host_addr),
        .count      (live_count),
        .hi_written (hi_written),
        .rdata      (host_rdata)
    );

    AST_NONDMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !host_wdata[CMD_DMA_BIT] && !xfer_done && !xfer_start && !beat_valid)
        |=> ($stable(live_count) && !dma_mode)); // R4

    AST_ZERO_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_count == '0 && !reload_req && !xfer_start) |=> (live_count == '0)); // R8

endmodule

// File: tb/dma_tcount_tb_top.sv
// Bench for dma_tcount: directed corner cases followed by seeded random
// traffic, each cycle compared with a reference model kept in the bench.
module dma_tcount_tb_top;

    localparam logic [7:0] CHIP = 8'h5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        xfer_start = 1'b0;
    logic        xfer_done = 1'b0;
    logic        beat_valid = 1'b0;
    logic        beat_wide = 1'b0;
    logic        beat_ready;
    logic [23:0] live_count;
    logic        tc_flag;
    logic        dma_mode;
    logic        proto_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference state
    logic [23:0] m_cnt;
    logic [23:0] m_sh;
    bit          m_tc, m_dma, m_perr, m_hiw;

    always #5 clk = ~clk;

    dma_tcount #(.CHIP_ID(CHIP)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_start(xfer_start),
        .xfer_done(xfer_done), .beat_valid(beat_valid), .beat_wide(beat_wide),
        .beat_ready(beat_ready), .live_count(live_count), .tc_flag(tc_flag),
        .dma_mode(dma_mode), .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt[7:0];
            2'd1: return m_cnt[15:8];
            2'd2: return m_hiw ? m_cnt[23:16] : CHIP;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit exp_ready(input bit wr, input logic [1:0] a, input logic [7:0] d, input bit dn);
        return (m_cnt != 0) && !dn && !(wr && a == 2'd3 && d[7]);
    endfunction

    task automatic check_state(input string req);
        chk(req, "live_count", live_count, m_cnt);
        chk(req, "tc_flag", tc_flag, m_tc);
        chk(req, "dma_mode", dma_mode, m_dma);
        chk(req, "proto_err", proto_err, m_perr);
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0; host_wr = 0; xfer_start = 0; xfer_done = 0; beat_valid = 0; beat_wide = 0;
        host_addr = 2'd2;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_sh = 0; m_tc = 0; m_dma = 0; m_perr = 0; m_hiw = 0;
        #1;
        check_state(req);
        chk(req, "rdata hi after reset", host_rdata, CHIP);
    endtask

    // One clock: drive, check combinational outputs, advance model, check registers.
    task automatic cyc(input bit wr, input logic [1:0] a, input logic [7:0] d,
                       input bit st, input bit dn, input bit bv, input bit bw);
        string tag;
        bit rl;
        @(negedge clk);
        host_wr = wr; host_addr = a; host_wdata = d;
        xfer_start = st; xfer_done = dn; beat_valid = bv; beat_wide = bw;
        #1;
        chk((m_cnt == 0) ? "R8" : "R7", "beat_ready", beat_ready, exp_ready(wr, a, d, dn));
        chk((a == 2'd2) ? "R5" : "R11", "host_rdata", host_rdata, exp_rd(a));
        rl = wr && a == 2'd3 && d[7];
        tag = "R8";
        if (dn) begin
            m_cnt = 0; m_tc = 1; tag = "R9";
        end else if (rl) begin
            m_cnt = m_sh; m_perr = 0; tag = "R3";
        end else if (st && m_cnt == 0) begin
            m_cnt = 24'h010000; tag = "R6";
        end else if (bv && m_cnt != 0) begin
            if (bw) begin
                if (m_cnt == 1) begin m_cnt = 0; m_perr = 1; tag = "R10"; end
                else begin m_cnt = m_cnt - 2; tag = "R7"; end
            end else begin
                m_cnt = m_cnt - 1; tag = "R7";
            end
        end else if (wr && a != 2'd3) begin
            tag = "R2";
        end else if (wr) begin
            tag = "R4";
        end
        if (wr && a != 2'd3) begin
            m_sh[a*8 +: 8] = d;
            if (!dn) m_tc = 0;
            if (a == 2'd2) m_hiw = 1;
        end
        if (wr && a == 2'd3) m_dma = d[7];
        @(posedge clk);
        cycles++;
        #2;
        check_state(tag);
    endtask

    task automatic idle_read(input logic [1:0] a);
        cyc(0, a, 8'h00, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1BADF00D));
        m_cnt = 0; m_sh = 0; m_tc = 0; m_dma = 0; m_perr = 0; m_hiw = 0;

        // R1 and R5: reset state, identifier visible on the high byte.
        do_reset("R1");
        idle_read(2'd2);

        // R2: shadow writes leave the live count alone.
        cyc(1, 2'd0, 8'h34, 0, 0, 0, 0);
        cyc(1, 2'd1, 8'h12, 0, 0, 0, 0);
        idle_read(2'd2);                    // R5: still the identifier
        // R4: command without DMA bit.
        cyc(1, 2'd3, 8'h01, 0, 0, 0, 0);
        // R3: reload, then R11 byte reads.
        cyc(1, 2'd3, 8'h80, 0, 0, 0, 0);
        idle_read(2'd0);
        idle_read(2'd1);
        idle_read(2'd3);
        // R7: narrow and wide beats.
        cyc(0, 2'd0, 8'h00, 0, 0, 1, 0);
        cyc(0, 2'd0, 8'h00, 0, 0, 1, 1);
        // R9: completion wins over a beat; R8: beats at zero ignored.
        cyc(0, 2'd0, 8'h00, 0, 1, 1, 0);
        cyc(0, 2'd0, 8'h00, 0, 0, 1, 1);
        // R6: zero-length start gives 0x10000, second start has no effect.
        cyc(0, 2'd0, 8'h00, 1, 0, 0, 0);
        cyc(0, 2'd0, 8'h00, 1, 0, 1, 0);
        // R10: wide beat at count 1.
        cyc(1, 2'd1, 8'h00, 0, 0, 0, 0);
        cyc(1, 2'd0, 8'h01, 0, 0, 0, 0);
        cyc(1, 2'd3, 8'h90, 0, 0, 0, 0);
        cyc(0, 2'd0, 8'h00, 0, 0, 1, 1);
        cyc(0, 2'd0, 8'h00, 0, 0, 1, 1);
        // R5: high write, then live high byte returned.
        cyc(1, 2'd2, 8'h7E, 0, 0, 0, 0);
        cyc(1, 2'd3, 8'h80, 0, 0, 0, 0);
        idle_read(2'd2);
        // R12: reset re-arms the identifier.
        do_reset("R12");
        idle_read(2'd2);

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            int sel;
            bit wr, st, dn, bv, bw;
            logic [1:0] a;
            logic [7:0] d;
            sel = $urandom_range(0, 99);
            wr = (sel < 30);
            a  = 2'($urandom_range(0, 3));
            d  = 8'($urandom_range(0, 255));
            if (wr && a != 2'd0 && a != 2'd3 && $urandom_range(0, 3) != 0) d = 8'h00;
            if (wr && a == 2'd0 && $urandom_range(0, 1) == 1) d = 8'($urandom_range(0, 4));
            st = ($urandom_range(0, 19) == 0);
            dn = ($urandom_range(0, 29) == 0);
            bv = ($urandom_range(0, 1) == 1);
            bw = ($urandom_range(0, 1) == 1);
            if (n == 2000) do_reset("R12");
            cyc(wr, a, d, st, dn, bv, bw);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule